// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the SD card bus clock from a faster reference clock. An 11-bit divider field, loaded through a simple write strobe, sets the division ratio to the field value plus two. The smallest ratio is therefore 2, which gives half the reference rate, and the all-ones field gives the slowest rate. The slowest rate is also the power-on setting and the usual card identification setting.

The block drives two outputs. One is the divided clock level, which goes to the card pin. The other is a one-reference-cycle enable pulse at each rising edge of that level, which the command and data engines use to advance their shift logic. Software may load a new field at any time. The new value waits in a pending register and is copied to the active divider only when the divided clock falls. The high and low phases already under way therefore always run to their full length, and no runt pulse can appear. For an odd ratio the high phase is one reference cycle shorter than the low phase.

Top module: `sdclk_divider`

## Requirements
- R1: After reset release the divided clock is low, the enable pulse is low and the active field is all ones (0x7FF). The clock first rises at the 1025th rising reference edge after release.
- R2: With field value F the divided clock period is F+2 reference cycles, so F = 0 gives one cycle high and one cycle low.
- R3: The low phase lasts ceil((F+2)/2) reference cycles.
- R4: The high phase lasts floor((F+2)/2) reference cycles. For an odd ratio it is one cycle shorter than the low phase. F = 0x7FF gives 1024 high and 1025 low; F = 0x7FE gives 1024 and 1024.
- R5: A field write takes effect at the first falling edge of the divided clock that occurs at a reference edge after the write edge. The high or low phase in progress keeps its old length. A write sampled on the same reference edge as a fall applies only at the following fall.
- R6: When several writes arrive before a fall, only the last one is applied.
- R7: The enable pulse is high for exactly the first reference cycle of each high phase and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_we_i | input | 1 | Write strobe for the divider field |
| div_wdata_i | input | 11 | New divider field value (F) |
| sd_clk_o | output | 1 | Divided clock level |
| sd_clk_rise_o | output | 1 | One-cycle pulse on each rise of sd_clk_o |

## Verification
A wrong count load shows at the ports as a high or low phase of the wrong length. It appears at the next edge of sd_clk_o, at most one half period after the fault. If the active divider is updated at the wrong time, a phase that was already running changes length within the current half period, or the new rate shows up one period early or late. A misplaced enable pulse is visible at once, because it fails to line up with the first high cycle of the divided clock.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Arithmetic is done on a fixed 16-bit width so that any DIV_W up to 15 fits.
  typedef logic [15:0] sdclk_len_t;

  // Division ratio for a divider field value.
  function automatic sdclk_len_t sdclk_ratio(input sdclk_len_t field);
    return field + 16'd2;
  endfunction

  // Number of reference cycles the divided clock stays high.
  function automatic sdclk_len_t sdclk_high_len(input sdclk_len_t field);
    return sdclk_ratio(field) >> 1;
  endfunction

  // Number of reference cycles the divided clock stays low (the longer half).
  function automatic sdclk_len_t sdclk_low_len(input sdclk_len_t field);
    return sdclk_ratio(field) - sdclk_high_len(field);
  endfunction

endpackage

// File: rtl/sdclk_div_regs.sv
module sdclk_div_regs #(
  parameter int unsigned     DIV_W   = 11,
  parameter logic [DIV_W-1:0] RST_DIV = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DIV_W-1:0] wdata_i,
  input  logic             apply_i,
  output logic [DIV_W-1:0] pend_o,
  output logic [DIV_W-1:0] act_o
);

  logic [DIV_W-1:0] pend_q;
  logic [DIV_W-1:0] act_q;

  // The pending value holds the most recent write.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= RST_DIV;
    end else if (we_i) begin
      pend_q <= wdata_i;
    end
  end

  // The active value follows the pending value only at a clock fall.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= RST_DIV;
    end else if (apply_i) begin
      act_q <= pend_q;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

endmodule

// File: rtl/sdclk_phase_ctr.sv
module sdclk_phase_ctr
  import sdclk_pkg::*;
#(
  parameter int unsigned      DIV_W   = 11,
  parameter logic [DIV_W-1:0] RST_DIV = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] act_div_i,
  input  logic [DIV_W-1:0] next_div_i,
  output logic             lvl_o,
  output logic             rise_o,
  output logic             rise_evt_o,
  output logic             fall_evt_o
);

  localparam int unsigned CNT_W = DIV_W;
  localparam logic [CNT_W-1:0] RST_LOAD =
    CNT_W'(sdclk_low_len(16'(RST_DIV)) - 16'd1);

  logic [CNT_W-1:0] cnt_q;
  logic             lvl_q;
  logic             rise_q;
  logic             phase_end;
  logic [CNT_W-1:0] hi_load;
  logic [CNT_W-1:0] lo_load;

  // The high phase uses the current active field. The low phase that starts
  // at a fall uses the field that is being applied at that same edge.
  assign hi_load   = CNT_W'(sdclk_high_len(16'(act_div_i)) - 16'd1);
  assign lo_load   = CNT_W'(sdclk_low_len(16'(next_div_i)) - 16'd1);
  assign phase_end = (cnt_q == '0);

  assign rise_evt_o = !lvl_q && phase_end;
  assign fall_evt_o = lvl_q && phase_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= RST_LOAD;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else if (rise_evt_o) begin
      cnt_q  <= hi_load;
      lvl_q  <= 1'b1;
      rise_q <= 1'b1;
    end else if (fall_evt_o) begin
      cnt_q  <= lo_load;
      lvl_q  <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      rise_q <= 1'b0;
    end
  end

  assign lvl_o  = lvl_q;
  assign rise_o = rise_q;

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider #(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk_ref_i,
  input  logic             rst_ni,
  input  logic             div_we_i,
  input  logic [DIV_W-1:0] div_wdata_i,
  output logic             sd_clk_o,
  output logic             sd_clk_rise_o
);

  localparam logic [DIV_W-1:0] DIV_SLOWEST = '1;

  logic [DIV_W-1:0] pend_div;
  logic [DIV_W-1:0] act_div;
  logic             rise_evt;
  logic             fall_evt;

  sdclk_div_regs #(
    .DIV_W  (DIV_W),
    .RST_DIV(DIV_SLOWEST)
  ) u_regs (
    .clk_i  (clk_ref_i),
    .rst_ni (rst_ni),
    .we_i   (div_we_i),
    .wdata_i(div_wdata_i),
    .apply_i(fall_evt),
    .pend_o (pend_div),
    .act_o  (act_div)
  );

  sdclk_phase_ctr #(
    .DIV_W  (DIV_W),
    .RST_DIV(DIV_SLOWEST)
  ) u_phase (
    .clk_i     (clk_ref_i),
    .rst_ni    (rst_ni),
    .act_div_i (act_div),
    .next_div_i(pend_div),
    .lvl_o     (sd_clk_o),
    .rise_o    (sd_clk_rise_o),
    .rise_evt_o(rise_evt),
    .fall_evt_o(fall_evt)
  );

endmodule

// File: rtl/sdclk_divider_chk.sv
module sdclk_divider_chk
  import sdclk_pkg::*;
#(
  parameter int unsigned DIV_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sd_clk_i,
  input logic             rise_i,
  input logic [DIV_W-1:0] act_div_i
);

  int unsigned lo_run;
  int unsigned hi_run;

  // Counts of consecutive low and high reference cycles, kept by the checker.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= 0;
      hi_run <= 0;
    end else begin
      lo_run <= sd_clk_i ? 0 : lo_run + 1;
      hi_run <= sd_clk_i ? hi_run + 1 : 0;
    end
  end

  a_r7_pulse_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |-> (sd_clk_i && !$past(sd_clk_i)));

  a_r7_rise_has_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_clk_i && !$past(sd_clk_i)) |-> rise_i);

  a_r7_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i |=> !rise_i);

  a_r3_low_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_clk_i && rise_i) |-> (lo_run == 32'(sdclk_low_len(16'(act_div_i)))));

  a_r4_high_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sd_clk_i && $past(sd_clk_i)) |->
      (hi_run == 32'(sdclk_high_len(16'($past(act_div_i))))));

  a_r5_apply_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_div_i) |-> (!sd_clk_i && $past(sd_clk_i)));

endmodule

bind sdclk_divider sdclk_divider_chk #(.DIV_W(DIV_W)) u_chk (
  .clk_i    (clk_ref_i),
  .rst_ni   (rst_ni),
  .sd_clk_i (sd_clk_o),
  .rise_i   (sd_clk_rise_o),
  .act_div_i(act_div)
);

// File: tb/sdclk_divider_bench.sv
`timescale 1ns/1ps
module sdclk_divider_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [10:0] wd = '0;
  logic        sd_clk;
  logic        rise;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sdclk_divider u_sdclk_divider (
    .clk_ref_i    (clk),
    .rst_ni       (rst_n),
    .div_we_i     (we),
    .div_wdata_i  (wd),
    .sd_clk_o     (sd_clk),
    .sd_clk_rise_o(rise)
  );

  // field, expected high cycles, expected low cycles
  localparam int NV = 8;
  localparam int VEC [0:NV-1][0:2] = '{
    '{0, 1, 1}, '{1, 1, 2}, '{2, 2, 2}, '{3, 2, 3},
    '{10, 6, 6}, '{37, 19, 20}, '{2046, 1024, 1024}, '{2047, 1024, 1025}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input int v);
    we = 1'b1;
    wd = 11'(v);
    @(negedge clk);
    we = 1'b0;
  endtask

  // Returns at the first sample after a fall seen at a later reference edge.
  task automatic wait_fall();
    logic p;
    p = sd_clk;
    forever begin
      @(negedge clk);
      if (p && !sd_clk) break;
      p = sd_clk;
    end
  endtask

  // Counts samples at level val; checks the enable pulse on the way.
  task automatic run_len(input logic val, output int n, output int pulse_bad);
    n = 0;
    pulse_bad = 0;
    while (sd_clk == val) begin
      n++;
      if (val && (rise != (n == 1))) pulse_bad++;
      if (!val && rise) pulse_bad++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, pb, lo, hi;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 clk low in reset", int'(sd_clk), 0);
    chk("R1 pulse low in reset", int'(rise), 0);
    rst_n = 1'b1;
    n = 0;
    while (!sd_clk) begin
      @(negedge clk);
      n++;
    end
    chk("R1 first rise edge (slowest field)", n, 1025);
    chk("R7 pulse at first rise", int'(rise), 1);

    // Vector table: R2/R3/R4/R7
    for (int i = 0; i < NV; i++) begin
      wr_div(VEC[i][0]);
      wait_fall();
      run_len(1'b0, lo, pb);
      chk($sformatf("R3 low len F=%0d", VEC[i][0]), lo, VEC[i][2]);
      chk($sformatf("R7 no pulse in low F=%0d", VEC[i][0]), pb, 0);
      run_len(1'b1, hi, pb);
      chk($sformatf("R4 high len F=%0d", VEC[i][0]), hi, VEC[i][1]);
      chk($sformatf("R7 pulse in high F=%0d", VEC[i][0]), pb, 0);
      chk($sformatf("R2 period F=%0d", VEC[i][0]), lo + hi, VEC[i][0] + 2);
    end

    // R5: write in the middle of a high phase leaves it intact
    wr_div(20);
    wait_fall();
    while (!sd_clk) @(negedge clk);
    hi = 0;
    while (sd_clk) begin
      hi++;
      we = (hi == 1);
      wd = 11'd0;
      @(negedge clk);
      we = 1'b0;
    end
    chk("R5 high phase after mid-phase write", hi, 11);
    run_len(1'b0, lo, pb);
    chk("R5 new low applied at fall", lo, 1);
    run_len(1'b1, hi, pb);
    chk("R5 new high applied", hi, 1);

    // R5: write on the same edge as a fall applies at the following fall
    wr_div(20);
    wait_fall();
    while (!sd_clk) @(negedge clk);
    hi = 0;
    while (sd_clk) begin
      hi++;
      we = (hi == 11);
      wd = 11'd0;
      @(negedge clk);
      we = 1'b0;
    end
    run_len(1'b0, lo, pb);
    chk("R5 write at fall edge: low keeps old", lo, 11);
    run_len(1'b1, hi, pb);
    chk("R5 write at fall edge: high keeps old", hi, 11);
    run_len(1'b0, lo, pb);
    chk("R5 write at fall edge: next low new", lo, 1);

    // R6: last of several writes wins
    wr_div(20);
    wait_fall();
    repeat (2) @(negedge clk);
    wr_div(5);
    wr_div(1);
    wait_fall();
    run_len(1'b0, lo, pb);
    chk("R6 last write low", lo, 2);
    run_len(1'b1, hi, pb);
    chk("R6 last write high", hi, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule